// File: doc/BRIEF.md
# Exclusive Word Access Handler

This block sits in the load-store path of a processor and carries out load-reserved (LR) and store-conditional (SC) word accesses over a request/grant data bus. The bus has an atomic-type sideband. A decoded request names the kind (LR or SC), the address, the store data and the destination register. The block turns that request into a single bus transaction tagged with the matching atomic code. It then reads the error and exclusive-okay bits that come back with the response, and from them produces either a register writeback or an exception.

The memory side owns the reservation set. This block never registers, clears or tracks a reservation. A return from a trap has no effect on the block, because the block holds no reservation state. Only one exclusive transaction may be in flight at a time. A busy output tells the pipeline to hold further requests until the current one has completed. A misaligned address is rejected locally with an exception, and the bus is not touched.

Top module: `excl_access_unit`

## Requirements
- R1: After reset, busy_o, bus_req_o, wb_valid_o and exc_valid_o are all low.
- R2: An aligned LR accepted at a clock edge (req_valid_i high while busy_o is low) makes bus_req_o high in the next cycle. In that cycle bus_we_o is low, bus_addr_o equals the request address, bus_be_o is all ones and bus_atop_o carries the LR code (default 6'h22). All of these stay unchanged until the cycle in which bus_gnt_i is high.
- R3: An aligned SC is issued in the same way, but with bus_we_o high, bus_wdata_o equal to the request store data, bus_be_o all ones and bus_atop_o carrying the SC code (default 6'h23).
- R4: busy_o is high from the cycle after acceptance until the response edge. While busy_o is high, req_valid_i is ignored: it starts no further bus request.
- R5: An address whose two low bits are not zero (for the default 32-bit data width) starts no bus request. In the next cycle it raises exc_valid_o with exc_cause_o = 1 (misaligned) and wb_valid_o stays low.
- R6: An LR response with bus_err_i low writes bus_rdata_i to the destination register, whatever the value of bus_exokay_i. wb_valid_o and wb_rd_o are valid in the cycle after bus_rvalid_i.
- R7: An SC response with bus_err_i low and bus_exokay_i high writes the value 0.
- R8: An SC response with bus_err_i low and bus_exokay_i low writes the value 1 and raises no exception.
- R9: A response with bus_err_i high, for either kind, raises exc_valid_o with exc_cause_o = 2 (bus fault) in the cycle after bus_rvalid_i, and makes no writeback.
- R10: Completion outputs last exactly one cycle. In that same cycle busy_o is already low, so a new request can be accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Decoded exclusive request present |
| req_is_sc_i | input | 1 | 1 = store-conditional, 0 = load-reserved |
| req_addr_i | input | ADDR_W | Request address |
| req_wdata_i | input | DATA_W | Store data for SC |
| req_rd_i | input | RD_W | Destination register index |
| busy_o | output | 1 | Transaction in flight; pipeline must stall |
| bus_req_o | output | 1 | Bus request |
| bus_gnt_i | input | 1 | Bus grant |
| bus_addr_o | output | ADDR_W | Bus address |
| bus_we_o | output | 1 | Bus write enable |
| bus_be_o | output | DATA_W/8 | Bus byte enables |
| bus_wdata_o | output | DATA_W | Bus write data |
| bus_atop_o | output | ATOP_W | Atomic-type sideband |
| bus_rvalid_i | input | 1 | Response valid |
| bus_rdata_i | input | DATA_W | Response read data |
| bus_err_i | input | 1 | Response bus error |
| bus_exokay_i | input | 1 | Response exclusive okay |
| wb_valid_o | output | 1 | Register writeback strobe |
| wb_rd_o | output | RD_W | Writeback register index |
| wb_data_o | output | DATA_W | Writeback value |
| exc_valid_o | output | 1 | Exception strobe |
| exc_cause_o | output | 2 | 1 = misaligned, 2 = bus fault |

## Verification
Two things can happen in one cycle: the completion report of one transaction and the acceptance of the next request. The report is the writeback or exception pulse, and it appears in the same cycle in which busy_o has just dropped. The bench provokes this by driving a new request at the very moment the previous response's result appears. It then checks that the result pulse is correct in that cycle, and that the new bus request appears in the following cycle carrying the new address and kind. A second overlap case is a request presented while busy_o is high. It is judged by counting rising edges of the bus request and checking that the ignored request never shows up on the bus.

// File: rtl/excl_pkg.sv
package excl_pkg;

   typedef enum logic [1:0] {
      CAUSE_NONE     = 2'd0,
      CAUSE_MISALIGN = 2'd1,
      CAUSE_BUSFAULT = 2'd2
   } exc_cause_e;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_ISSUE = 2'd1,
      ST_WAIT  = 2'd2
   } xfer_state_e;

endpackage

// File: rtl/excl_align_chk.sv
module excl_align_chk #(
   parameter int ADDR_W = 32,
   parameter int OFS_W  = 2
) (
   input  logic [ADDR_W-1:0] addr_i,
   output logic              misaligned_o
);
   logic [OFS_W-1:0] low_bits;

   for (genvar g = 0; g < OFS_W; g++) begin : g_low
      assign low_bits[g] = addr_i[g];
   end

   assign misaligned_o = |low_bits;
endmodule

// File: rtl/excl_issue.sv
module excl_issue
   import excl_pkg::*;
#(
   parameter int          ADDR_W  = 32,
   parameter int          DATA_W  = 32,
   parameter int          RD_W    = 5,
   parameter int          ATOP_W  = 6,
   parameter logic [ATOP_W-1:0] ATOP_LR = 6'h22,
   parameter logic [ATOP_W-1:0] ATOP_SC = 6'h23
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              req_valid_i,
   input  logic              req_is_sc_i,
   input  logic [ADDR_W-1:0] req_addr_i,
   input  logic [DATA_W-1:0] req_wdata_i,
   input  logic [RD_W-1:0]   req_rd_i,
   input  logic              misaligned_i,
   output logic              busy_o,
   output logic              mis_fire_o,
   output logic              resp_fire_o,
   output logic              held_sc_o,
   output logic [RD_W-1:0]   held_rd_o,
   output logic              bus_req_o,
   input  logic              bus_gnt_i,
   output logic [ADDR_W-1:0] bus_addr_o,
   output logic              bus_we_o,
   output logic [DATA_W/8-1:0] bus_be_o,
   output logic [DATA_W-1:0] bus_wdata_o,
   output logic [ATOP_W-1:0] bus_atop_o,
   input  logic              bus_rvalid_i
);
   localparam int BE_W = DATA_W / 8;

   xfer_state_e       state_q, state_d;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] wdata_q;
   logic [RD_W-1:0]   rd_q;
   logic              sc_q;
   logic              accept, launch;

   assign accept = req_valid_i && (state_q == ST_IDLE);
   assign launch = accept && !misaligned_i;

   always_comb begin
      state_d = state_q;
      unique case (state_q)
         ST_IDLE:  if (launch)       state_d = ST_ISSUE;
         ST_ISSUE: if (bus_gnt_i)    state_d = ST_WAIT;
         ST_WAIT:  if (bus_rvalid_i) state_d = ST_IDLE;
         default:                    state_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_IDLE;
         addr_q  <= '0;
         wdata_q <= '0;
         rd_q    <= '0;
         sc_q    <= 1'b0;
      end else begin
         state_q <= state_d;
         if (launch) begin
            addr_q  <= req_addr_i;
            wdata_q <= req_is_sc_i ? req_wdata_i : '0;
            rd_q    <= req_rd_i;
            sc_q    <= req_is_sc_i;
         end
      end
   end

   assign bus_req_o   = (state_q == ST_ISSUE);
   assign bus_addr_o  = addr_q;
   assign bus_we_o    = bus_req_o && sc_q;
   assign bus_wdata_o = wdata_q;
   assign bus_atop_o  = bus_req_o ? (sc_q ? ATOP_SC : ATOP_LR) : '0;

   for (genvar b = 0; b < BE_W; b++) begin : g_be
      assign bus_be_o[b] = bus_req_o;
   end

   assign busy_o      = (state_q != ST_IDLE);
   assign mis_fire_o  = accept && misaligned_i;
   assign resp_fire_o = (state_q == ST_WAIT) && bus_rvalid_i;
   assign held_sc_o   = sc_q;
   assign held_rd_o   = rd_q;

   a_r2_hold_until_gnt: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(bus_addr_o) &&
         $stable(bus_atop_o) && $stable(bus_we_o) && $stable(bus_wdata_o)));

   a_r3_we_matches_kind: assert property (@(posedge clk_i) disable iff (!rst_ni)
      bus_req_o |-> (bus_we_o == (bus_atop_o == ATOP_SC)) && (&bus_be_o));

   a_r4_one_outstanding: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(bus_req_o) |-> $past(req_valid_i && !busy_o));

   a_r5_misalign_no_bus: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && !busy_o && misaligned_i) |=> !bus_req_o);
endmodule

// File: rtl/excl_resp_decode.sv
module excl_resp_decode
   import excl_pkg::*;
#(
   parameter int DATA_W = 32,
   parameter int RD_W   = 5
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              mis_fire_i,
   input  logic              resp_fire_i,
   input  logic              held_sc_i,
   input  logic [RD_W-1:0]   held_rd_i,
   input  logic [DATA_W-1:0] bus_rdata_i,
   input  logic              bus_err_i,
   input  logic              bus_exokay_i,
   output logic              wb_valid_o,
   output logic [RD_W-1:0]   wb_rd_o,
   output logic [DATA_W-1:0] wb_data_o,
   output logic              exc_valid_o,
   output logic [1:0]        exc_cause_o
);
   logic              wb_d;
   logic [DATA_W-1:0] value_d;
   logic              fault_d;
   exc_cause_e        cause_d;

   always_comb begin
      wb_d    = resp_fire_i && !bus_err_i;
      value_d = held_sc_i ? {{(DATA_W-1){1'b0}}, ~bus_exokay_i} : bus_rdata_i;
      fault_d = mis_fire_i || (resp_fire_i && bus_err_i);
      cause_d = mis_fire_i ? CAUSE_MISALIGN :
                (resp_fire_i && bus_err_i) ? CAUSE_BUSFAULT : CAUSE_NONE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         wb_valid_o  <= 1'b0;
         wb_rd_o     <= '0;
         wb_data_o   <= '0;
         exc_valid_o <= 1'b0;
         exc_cause_o <= CAUSE_NONE;
      end else begin
         wb_valid_o  <= wb_d;
         exc_valid_o <= fault_d;
         exc_cause_o <= cause_d;
         if (wb_d) begin
            wb_rd_o   <= held_rd_i;
            wb_data_o <= value_d;
         end
      end
   end

   a_r9_err_no_writeback: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (resp_fire_i && bus_err_i) |=> (!wb_valid_o && exc_valid_o && exc_cause_o == 2'd2));

   a_r9_outputs_exclusive: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(wb_valid_o && exc_valid_o));

   a_r10_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wb_valid_o || exc_valid_o) |=> !(wb_valid_o || exc_valid_o) || $past(mis_fire_i) ||
         $past(resp_fire_i));

   a_r8_sc_fail_no_exc: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (resp_fire_i && held_sc_i && !bus_err_i && !bus_exokay_i) |=>
         (wb_valid_o && !exc_valid_o && wb_data_o == DATA_W'(1)));
endmodule

// File: rtl/excl_access_unit.sv
module excl_access_unit
   import excl_pkg::*;
#(
   parameter int          ADDR_W  = 32,
   parameter int          DATA_W  = 32,
   parameter int          RD_W    = 5,
   parameter int          ATOP_W  = 6,
   parameter logic [ATOP_W-1:0] ATOP_LR = 6'h22,
   parameter logic [ATOP_W-1:0] ATOP_SC = 6'h23
) (
   input  logic                clk_i,
   input  logic                rst_ni,
   input  logic                req_valid_i,
   input  logic                req_is_sc_i,
   input  logic [ADDR_W-1:0]   req_addr_i,
   input  logic [DATA_W-1:0]   req_wdata_i,
   input  logic [RD_W-1:0]     req_rd_i,
   output logic                busy_o,
   output logic                bus_req_o,
   input  logic                bus_gnt_i,
   output logic [ADDR_W-1:0]   bus_addr_o,
   output logic                bus_we_o,
   output logic [DATA_W/8-1:0] bus_be_o,
   output logic [DATA_W-1:0]   bus_wdata_o,
   output logic [ATOP_W-1:0]   bus_atop_o,
   input  logic                bus_rvalid_i,
   input  logic [DATA_W-1:0]   bus_rdata_i,
   input  logic                bus_err_i,
   input  logic                bus_exokay_i,
   output logic                wb_valid_o,
   output logic [RD_W-1:0]     wb_rd_o,
   output logic [DATA_W-1:0]   wb_data_o,
   output logic                exc_valid_o,
   output logic [1:0]          exc_cause_o
);
   localparam int BE_W  = DATA_W / 8;
   localparam int OFS_W = $clog2(BE_W);

   if (DATA_W % 8 != 0 || DATA_W < 16 || (BE_W & (BE_W - 1)) != 0) begin : g_bad_data_w
      $error("DATA_W must be a power-of-two byte multiple of at least 16");
   end
   if (ATOP_LR == ATOP_SC) begin : g_bad_atop
      $error("LR and SC atomic codes must differ");
   end
   if (ADDR_W <= OFS_W) begin : g_bad_addr_w
      $error("ADDR_W too small for word offset");
   end

   logic              misaligned;
   logic              mis_fire, resp_fire, held_sc;
   logic [RD_W-1:0]   held_rd;

   excl_align_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_align (
      .addr_i       (req_addr_i),
      .misaligned_o (misaligned)
   );

   excl_issue #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .RD_W(RD_W), .ATOP_W(ATOP_W),
      .ATOP_LR(ATOP_LR), .ATOP_SC(ATOP_SC)
   ) u_issue (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .req_valid_i  (req_valid_i),
      .req_is_sc_i  (req_is_sc_i),
      .req_addr_i   (req_addr_i),
      .req_wdata_i  (req_wdata_i),
      .req_rd_i     (req_rd_i),
      .misaligned_i (misaligned),
      .busy_o       (busy_o),
      .mis_fire_o   (mis_fire),
      .resp_fire_o  (resp_fire),
      .held_sc_o    (held_sc),
      .held_rd_o    (held_rd),
      .bus_req_o    (bus_req_o),
      .bus_gnt_i    (bus_gnt_i),
      .bus_addr_o   (bus_addr_o),
      .bus_we_o     (bus_we_o),
      .bus_be_o     (bus_be_o),
      .bus_wdata_o  (bus_wdata_o),
      .bus_atop_o   (bus_atop_o),
      .bus_rvalid_i (bus_rvalid_i)
   );

   excl_resp_decode #(.DATA_W(DATA_W), .RD_W(RD_W)) u_decode (
      .clk_i        (clk_i),
      .rst_ni       (rst_ni),
      .mis_fire_i   (mis_fire),
      .resp_fire_i  (resp_fire),
      .held_sc_i    (held_sc),
      .held_rd_i    (held_rd),
      .bus_rdata_i  (bus_rdata_i),
      .bus_err_i    (bus_err_i),
      .bus_exokay_i (bus_exokay_i),
      .wb_valid_o   (wb_valid_o),
      .wb_rd_o      (wb_rd_o),
      .wb_data_o    (wb_data_o),
      .exc_valid_o  (exc_valid_o),
      .exc_cause_o  (exc_cause_o)
   );

   a_r10_free_on_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wb_valid_o || (exc_valid_o && exc_cause_o == 2'd2)) |-> !busy_o);

   a_r5_misalign_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_valid_i && !busy_o && misaligned) |=>
         (exc_valid_o && exc_cause_o == 2'd1 && !wb_valid_o));
endmodule

// File: tb/excl_access_unit_tb_top.sv
module excl_access_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        req_valid = 1'b0, req_is_sc = 1'b0;
   logic [31:0] req_addr = '0, req_wdata = '0;
   logic [4:0]  req_rd = '0;
   logic        busy, bus_req, bus_gnt = 1'b0, bus_we;
   logic [31:0] bus_addr, bus_wdata;
   logic [3:0]  bus_be;
   logic [5:0]  bus_atop;
   logic        bus_rvalid = 1'b0, bus_err = 1'b0, bus_exokay = 1'b0;
   logic [31:0] bus_rdata = '0;
   logic        wb_valid, exc_valid;
   logic [4:0]  wb_rd;
   logic [31:0] wb_data;
   logic [1:0]  exc_cause;

   int n_chk = 0, n_fail = 0, req_rises = 0;
   logic prev_req = 1'b0;

   always #2.5 clk = ~clk;

   excl_access_unit dut_i (
      .clk_i(clk), .rst_ni(rst_n),
      .req_valid_i(req_valid), .req_is_sc_i(req_is_sc), .req_addr_i(req_addr),
      .req_wdata_i(req_wdata), .req_rd_i(req_rd), .busy_o(busy),
      .bus_req_o(bus_req), .bus_gnt_i(bus_gnt), .bus_addr_o(bus_addr),
      .bus_we_o(bus_we), .bus_be_o(bus_be), .bus_wdata_o(bus_wdata),
      .bus_atop_o(bus_atop), .bus_rvalid_i(bus_rvalid), .bus_rdata_i(bus_rdata),
      .bus_err_i(bus_err), .bus_exokay_i(bus_exokay), .wb_valid_o(wb_valid),
      .wb_rd_o(wb_rd), .wb_data_o(wb_data), .exc_valid_o(exc_valid),
      .exc_cause_o(exc_cause)
   );

   always @(posedge clk) begin
      if (bus_req && !prev_req) req_rises <= req_rises + 1;
      prev_req <= bus_req;
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   typedef struct packed {
      logic        sc;
      logic [31:0] addr;
      logic [31:0] wdata;
      logic [4:0]  rd;
      logic [1:0]  gdly;
      logic [1:0]  rdly;
      logic        err;
      logic        exok;
      logic [31:0] rdata;
   } vec_t;

   localparam int NV = 8;
   localparam vec_t VECS [NV] = '{
      '{1'b0, 32'h0000_1000, 32'h0,         5'd3,  2'd0, 2'd0, 1'b0, 1'b1, 32'hCAFE_0001},
      '{1'b0, 32'h0000_2004, 32'h0,         5'd7,  2'd2, 2'd1, 1'b0, 1'b0, 32'h1234_5678},
      '{1'b1, 32'h0000_3008, 32'hDEAD_BEEF, 5'd9,  2'd1, 2'd0, 1'b0, 1'b1, 32'hFFFF_FFFF},
      '{1'b1, 32'h0000_300C, 32'h0BAD_F00D, 5'd10, 2'd0, 2'd2, 1'b0, 1'b0, 32'h0},
      '{1'b0, 32'h0000_4010, 32'h0,         5'd11, 2'd3, 2'd0, 1'b1, 1'b0, 32'h5555_AAAA},
      '{1'b1, 32'h0000_4014, 32'h7777_1111, 5'd12, 2'd0, 2'd3, 1'b1, 1'b0, 32'h0},
      '{1'b1, 32'h8000_0000, 32'h0000_0001, 5'd31, 2'd2, 2'd2, 1'b0, 1'b1, 32'h0},
      '{1'b0, 32'hFFFF_FFFC, 32'h0,         5'd1,  2'd1, 2'd1, 1'b0, 1'b1, 32'h8000_0000}
   };

   // Presents one request at a negedge; leaves req_valid low after acceptance.
   task automatic present(input vec_t v);
      req_valid = 1'b1; req_is_sc = v.sc; req_addr = v.addr;
      req_wdata = v.wdata; req_rd = v.rd;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   // Bus side plus checks, entered one cycle after acceptance (at a negedge).
   task automatic serve(input vec_t v, input string tg);
      logic [31:0] exp_data;
      chk(bus_req == 1'b1, {tg, " bus_req"}, bus_req, 1);
      chk(bus_addr == v.addr, {tg, " addr"}, bus_addr, v.addr);
      chk(bus_we == v.sc, v.sc ? "R3 we" : "R2 we", bus_we, v.sc);
      chk(bus_be == 4'hF, v.sc ? "R3 be" : "R2 be", bus_be, 4'hF);
      chk(bus_atop == (v.sc ? 6'h23 : 6'h22), v.sc ? "R3 atop" : "R2 atop",
          bus_atop, v.sc ? 6'h23 : 6'h22);
      if (v.sc) chk(bus_wdata == v.wdata, "R3 wdata", bus_wdata, v.wdata);
      chk(busy == 1'b1, "R4 busy", busy, 1);
      for (int i = 0; i < v.gdly; i++) begin
         @(negedge clk);
         chk(bus_req && bus_addr == v.addr, "R2 held before grant", bus_addr, v.addr);
      end
      bus_gnt = 1'b1;
      @(negedge clk);
      bus_gnt = 1'b0;
      chk(bus_req == 1'b0, "R4 req dropped after grant", bus_req, 0);
      for (int i = 0; i < v.rdly; i++) @(negedge clk);
      bus_rvalid = 1'b1; bus_err = v.err; bus_exokay = v.exok; bus_rdata = v.rdata;
      @(negedge clk);
      bus_rvalid = 1'b0; bus_err = 1'b0; bus_exokay = 1'b0; bus_rdata = '0;
      exp_data = v.sc ? {31'b0, ~v.exok} : v.rdata;
      if (v.err) begin
         chk(!wb_valid && exc_valid && exc_cause == 2'd2, "R9 bus fault",
             {wb_valid, exc_valid, exc_cause}, {1'b0, 1'b1, 2'd2});
      end else begin
         chk(wb_valid && !exc_valid, v.sc ? (v.exok ? "R7 valid" : "R8 valid") : "R6 valid",
             {wb_valid, exc_valid}, 2'b10);
         chk(wb_data == exp_data, v.sc ? (v.exok ? "R7 data" : "R8 data") : "R6 data",
             wb_data, exp_data);
         chk(wb_rd == v.rd, "R6 rd", wb_rd, v.rd);
      end
      chk(busy == 1'b0, "R10 free with result", busy, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_fail + 1 - 1, n_chk + 1);
      $finish;
   end

   initial begin
      vec_t v, w;
      int rises0;
      repeat (3) @(negedge clk);
      // R1: reset state
      chk(!busy && !bus_req && !wb_valid && !exc_valid, "R1 reset",
          {busy, bus_req, wb_valid, exc_valid}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!busy && !bus_req, "R1 after release", {busy, bus_req}, 0);

      for (int k = 0; k < NV; k++) begin
         present(VECS[k]);
         serve(VECS[k], VECS[k].sc ? "R3" : "R2");
         @(negedge clk);
         chk(!wb_valid && !exc_valid, "R10 one-cycle pulse", {wb_valid, exc_valid}, 0);
      end

      // R5: misaligned SC and LR
      v = '{1'b1, 32'h0000_5002, 32'h1, 5'd4, 2'd0, 2'd0, 1'b0, 1'b0, 32'h0};
      rises0 = req_rises;
      present(v);
      chk(!bus_req && exc_valid && exc_cause == 2'd1 && !wb_valid, "R5 misaligned SC",
          {bus_req, exc_valid, exc_cause, wb_valid}, {1'b0, 1'b1, 2'd1, 1'b0});
      chk(!busy, "R5 not busy", busy, 0);
      v.sc = 1'b0; v.addr = 32'h0000_5001;
      present(v);
      chk(exc_valid && exc_cause == 2'd1, "R5 misaligned LR", {exc_valid, exc_cause}, 3'b101);
      @(negedge clk);
      chk(req_rises == rises0 && !exc_valid, "R5 no bus traffic", req_rises, rises0);

      // R4: request while busy is ignored
      v = '{1'b0, 32'h0000_6000, 32'h0, 5'd5, 2'd0, 2'd1, 1'b0, 1'b1, 32'hABCD_0000};
      rises0 = req_rises;
      present(v);
      req_valid = 1'b1; req_is_sc = 1'b1; req_addr = 32'h0000_7000;
      serve(v, "R4 busy txn");
      req_valid = 1'b0;
      @(negedge clk);
      @(negedge clk);
      chk(req_rises == rises0 + 1 && !bus_req, "R4 ignored while busy", req_rises, rises0 + 1);

      // R10: new request accepted in the cycle the result appears
      v = '{1'b1, 32'h0000_8000, 32'h1111_2222, 5'd6, 2'd0, 2'd0, 1'b0, 1'b1, 32'h0};
      w = '{1'b0, 32'h0000_9000, 32'h0, 5'd8, 2'd1, 2'd0, 1'b0, 1'b0, 32'h4242_4242};
      present(v);
      serve(v, "R10 first");
      present(w);
      chk(!wb_valid, "R10 result gone", wb_valid, 0);
      serve(w, "R10 back-to-back");
      @(negedge clk);

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule